// File: doc/BRIEF.md
# Wavefront initial register loader

This block turns a captured compute dispatch descriptor into the ordered list of scalar register writes that seed a new wavefront. A start pulse captures the descriptor along with two enable words. The descriptor holds the segment buffer descriptor, the 64-bit pointers and ID, the grid and work-group sizes, the private segment size and the per-wave values. The block then emits one write per clock as an (index, 32-bit data) pair. User fields come first and are packed densely from index 0. They are cut off at sixteen registers. The per-wave system registers follow directly after the last user register.

Before emission starts, one shared serial divider computes the three grid work-group counts as ceiling quotients. A zero work-group size gives a count of zero and raises an error flag. The block also reports how many user registers the enables ask for, saturated at sixteen. A one-cycle done pulse closes each sequence.

Top module: `wave_init_loader`

## Requirements
- R1: User fields are emitted in this fixed order with these widths in registers: segment buffer descriptor (4), dispatch pointer (2), queue pointer (2), kernel-argument pointer (2), dispatch ID (2), flat scratch init (2), private segment size (1), work-group count X, Y, Z (1 each). Their enables are `propEn` bits 0 to 9 in that order. Multi-word values go out least significant word first. Flat scratch init is the scratch offset, then the rounded private size.
- R2: Write indices are dense. The first enabled register gets index 0, and each following write gets the previous index plus one. Disabled fields take no index.
- R3: At most 16 user registers are written, and any enabled user register past index 15 is dropped. `userCount` equals the number of enabled user registers, saturated at 16.
- R4: Each work-group count is ceil(grid / wgSize) for its dimension. When wgSize is 0, the count is 0 and `wgSizeErr` goes high until the next accepted start.
- R5: The private segment size value is the byte size rounded up to a multiple of 4, modulo 2^32.
- R6: System registers follow the last user register in this order: work-group ID X, Y, Z, then info, then wave byte offset. Their enables are `sysEn` bits 0 to 4 in that order. The info word is {firstWave, 14 zero bits, orderedTerm[10:0], wavesInGroup[5:0]}.
- R7: When `sysEn` bit 2 (ID Z) is set, work-group ID Y is written even if `sysEn` bit 1 is clear.
- R8: Writes come on consecutive cycles with `outValid` high. `done` is high for exactly the one cycle after the final write, or the one cycle after the counts are computed when nothing is enabled. A start pulse during a sequence is ignored. The descriptor is captured in the cycle `start` is accepted.
- R9: After reset, `outValid`, `outIdx`, `outData`, `done`, `userCount` and `wgSizeErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| propEn | input | 10 | User field enables, bit 0 = segment buffer ... bit 9 = count Z |
| sysEn | input | 5 | System register enables, bit 0 = ID X ... bit 4 = wave offset |
| segBufDesc | input | 128 | Segment buffer descriptor |
| dispatchPtr | input | 64 | Dispatch packet address |
| queuePtr | input | 64 | Queue object address |
| kernargPtr | input | 64 | Kernel-argument segment address |
| dispatchId | input | 64 | Dispatch identifier |
| scratchOffset | input | 32 | Flat scratch byte offset |
| privSegBytes | input | 32 | Per work-item private segment bytes |
| gridX | input | 32 | Grid size X |
| gridY | input | 32 | Grid size Y |
| gridZ | input | 32 | Grid size Z |
| wgSizeX | input | 32 | Work-group size X |
| wgSizeY | input | 32 | Work-group size Y |
| wgSizeZ | input | 32 | Work-group size Z |
| wgIdX | input | 32 | Work-group ID X |
| wgIdY | input | 32 | Work-group ID Y |
| wgIdZ | input | 32 | Work-group ID Z |
| firstWave | input | 1 | First-wave flag for the info word |
| orderedTerm | input | 11 | Ordered append term for the info word |
| wavesInGroup | input | 6 | Work-group size in waves for the info word |
| waveByteOffset | input | 32 | Private segment wave byte offset |
| outValid | output | 1 | A register write is presented |
| outIdx | output | 5 | Destination register index |
| outData | output | 32 | Register data |
| done | output | 1 | One-cycle end-of-sequence pulse |
| userCount | output | 5 | Enabled user registers, saturated at 16 |
| wgSizeErr | output | 1 | A captured work-group size was zero |

## Verification
The tests cover several enable patterns, and each one separates a different behaviour. Everything enabled overflows the cap and shows which fields are dropped. Exactly sixteen user registers places the first system register at index 16 with nothing dropped. A sparse pattern shows that indices close up across gaps. Setting only ID Z shows that ID Y is forced on. Nothing enabled shows that `done` still arrives with no writes. The count tests use sizes that divide evenly, sizes that leave a remainder, a maximal grid with size 1, and a zero size, which tells ceiling division apart from floor division and shows the error path. A second start with different inputs in the middle of a sequence shows that the captured descriptor drives the whole sequence.

// File: rtl/wil_pkg.sv
package wil_pkg;

  localparam int RegW       = 32;
  localparam int UserFields = 10;
  localparam int UserSlots  = 18;
  localparam int SysSlots   = 5;
  localparam int SlotCount  = UserSlots + SysSlots;
  localparam int SlotW      = $clog2(SlotCount);
  localparam int Dims       = 3;

  typedef enum logic [1:0] {
    CtlIdle,
    CtlDivLoad,
    CtlDivWait,
    CtlEmit
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       latch;
    logic       divStart;
    logic [1:0] divSel;
    logic       saveCnt;
    logic       emit;
  } dpStrobe_t;

  // maps a user register slot to the enable bit of its field
  function automatic int fieldOfSlot(input int s);
    if (s < 4)       return 0;
    else if (s < 14) return 1 + (s - 4) / 2;
    else             return s - 8;
  endfunction

endpackage

// File: rtl/wil_divider.sv
module wil_divider #(
  parameter int Width = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [Width-1:0] dividend,
  input  logic [Width-1:0] divisor,
  output logic [Width-1:0] quotient,
  output logic [Width-1:0] remainder,
  output logic             done
);
  localparam int CntW = $clog2(Width + 1);

  logic [Width-1:0] quoQ, remQ;
  logic [CntW-1:0]  cntQ;
  logic             busyQ, doneQ;
  logic [Width:0]   remShift, remDiff;

  always_comb begin
    remShift = {remQ, quoQ[Width-1]};
    remDiff  = remShift - {1'b0, divisor};
  end

  // restoring division, one quotient bit per cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoQ  <= '0;
      remQ  <= '0;
      cntQ  <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (start) begin
        quoQ  <= dividend;
        remQ  <= '0;
        cntQ  <= CntW'(Width);
        busyQ <= 1'b1;
      end else if (busyQ) begin
        if (remShift >= {1'b0, divisor}) begin
          remQ <= remDiff[Width-1:0];
          quoQ <= {quoQ[Width-2:0], 1'b1};
        end else begin
          remQ <= remShift[Width-1:0];
          quoQ <= {quoQ[Width-2:0], 1'b0};
        end
        cntQ <= cntQ - 1'b1;
        if (cntQ == CntW'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quoQ;
  assign remainder = remQ;
  assign done      = doneQ;

endmodule

// File: rtl/wil_datapath.sv
module wil_datapath import wil_pkg::*; #(
  parameter int MaxUserRegs = 16,
  parameter int IdxW        = 5,
  parameter int CntW        = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [UserFields-1:0] propEn,
  input  logic [SysSlots-1:0]   sysEn,
  input  logic [127:0]          segBufDesc,
  input  logic [63:0]           dispatchPtr,
  input  logic [63:0]           queuePtr,
  input  logic [63:0]           kernargPtr,
  input  logic [63:0]           dispatchId,
  input  logic [RegW-1:0]       scratchOffset,
  input  logic [RegW-1:0]       privSegBytes,
  input  logic [RegW-1:0]       gridX,
  input  logic [RegW-1:0]       gridY,
  input  logic [RegW-1:0]       gridZ,
  input  logic [RegW-1:0]       wgSizeX,
  input  logic [RegW-1:0]       wgSizeY,
  input  logic [RegW-1:0]       wgSizeZ,
  input  logic [RegW-1:0]       wgIdX,
  input  logic [RegW-1:0]       wgIdY,
  input  logic [RegW-1:0]       wgIdZ,
  input  logic                  firstWave,
  input  logic [10:0]           orderedTerm,
  input  logic [5:0]            wavesInGroup,
  input  logic [RegW-1:0]       waveByteOffset,
  output logic                  divDone,
  output logic                  pendEmpty,
  output logic                  outValid,
  output logic [IdxW-1:0]       outIdx,
  output logic [RegW-1:0]       outData,
  output logic [CntW-1:0]       userCount,
  output logic                  wgSizeErr
);

  // captured descriptor
  logic [127:0]    segBufQ;
  logic [63:0]     dispPtrQ, queuePtrQ, kargPtrQ, dispIdQ;
  logic [RegW-1:0] scratchOffQ, privRoundQ, infoQ, waveOffQ;
  logic [RegW-1:0] wgIdQ   [Dims];
  logic [RegW-1:0] gridQ   [Dims];
  logic [RegW-1:0] wgSizeQ [Dims];
  logic [RegW-1:0] countQ  [Dims];

  logic [SlotCount-1:0] pendQ;
  logic [IdxW-1:0]      idxQ;
  logic [CntW-1:0]      userCountQ;
  logic                 errQ;
  logic                 outValidQ;
  logic [IdxW-1:0]      outIdxQ;
  logic [RegW-1:0]      outDataQ;

  // user enables expanded per register slot
  logic [UserSlots-1:0] userExp, userKeep;
  logic [SysSlots-1:0]  sysNext;
  logic [CntW-1:0]      userCntNext;

  for (genvar s = 0; s < UserSlots; s++) begin : g_expand
    assign userExp[s] = propEn[fieldOfSlot(s)];
  end

  always_comb begin
    int run;
    run = 0;
    for (int s = 0; s < UserSlots; s++) begin
      userKeep[s] = userExp[s] && (run < MaxUserRegs);
      if (userExp[s]) run = run + 1;
    end
    userCntNext = (run > MaxUserRegs) ? CntW'(MaxUserRegs) : CntW'(run);
    sysNext     = sysEn;
    sysNext[1]  = sysEn[1] | sysEn[2];
  end

  // lowest pending slot goes out next
  logic [SlotW-1:0] pick;
  always_comb begin
    pick = '0;
    for (int s = SlotCount - 1; s >= 0; s--) begin
      if (pendQ[s]) pick = SlotW'(s);
    end
  end

  logic [RegW-1:0] slotData;
  always_comb begin
    case (int'(pick))
      0:       slotData = segBufQ[31:0];
      1:       slotData = segBufQ[63:32];
      2:       slotData = segBufQ[95:64];
      3:       slotData = segBufQ[127:96];
      4:       slotData = dispPtrQ[31:0];
      5:       slotData = dispPtrQ[63:32];
      6:       slotData = queuePtrQ[31:0];
      7:       slotData = queuePtrQ[63:32];
      8:       slotData = kargPtrQ[31:0];
      9:       slotData = kargPtrQ[63:32];
      10:      slotData = dispIdQ[31:0];
      11:      slotData = dispIdQ[63:32];
      12:      slotData = scratchOffQ;
      13:      slotData = privRoundQ;
      14:      slotData = privRoundQ;
      15:      slotData = countQ[0];
      16:      slotData = countQ[1];
      17:      slotData = countQ[2];
      18:      slotData = wgIdQ[0];
      19:      slotData = wgIdQ[1];
      20:      slotData = wgIdQ[2];
      21:      slotData = infoQ;
      22:      slotData = waveOffQ;
      default: slotData = '0;
    endcase
  end

  // shared divider for the three counts
  logic [RegW-1:0] divQuo, divRem;

  wil_divider #(.Width(RegW)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strb.divStart),
    .dividend (gridQ[strb.divSel]),
    .divisor  (wgSizeQ[strb.divSel]),
    .quotient (divQuo),
    .remainder(divRem),
    .done     (divDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segBufQ     <= '0;
      dispPtrQ    <= '0;
      queuePtrQ   <= '0;
      kargPtrQ    <= '0;
      dispIdQ     <= '0;
      scratchOffQ <= '0;
      privRoundQ  <= '0;
      infoQ       <= '0;
      waveOffQ    <= '0;
      for (int d = 0; d < Dims; d++) begin
        wgIdQ[d]   <= '0;
        gridQ[d]   <= '0;
        wgSizeQ[d] <= '0;
        countQ[d]  <= '0;
      end
      pendQ      <= '0;
      idxQ       <= '0;
      userCountQ <= '0;
      errQ       <= 1'b0;
      outValidQ  <= 1'b0;
      outIdxQ    <= '0;
      outDataQ   <= '0;
    end else begin
      if (strb.latch) begin
        segBufQ     <= segBufDesc;
        dispPtrQ    <= dispatchPtr;
        queuePtrQ   <= queuePtr;
        kargPtrQ    <= kernargPtr;
        dispIdQ     <= dispatchId;
        scratchOffQ <= scratchOffset;
        privRoundQ  <= (privSegBytes + RegW'(3)) & ~RegW'(3);
        infoQ       <= {firstWave, 14'b0, orderedTerm, wavesInGroup};
        waveOffQ    <= waveByteOffset;
        wgIdQ[0]    <= wgIdX;
        wgIdQ[1]    <= wgIdY;
        wgIdQ[2]    <= wgIdZ;
        gridQ[0]    <= gridX;
        gridQ[1]    <= gridY;
        gridQ[2]    <= gridZ;
        wgSizeQ[0]  <= wgSizeX;
        wgSizeQ[1]  <= wgSizeY;
        wgSizeQ[2]  <= wgSizeZ;
        pendQ       <= {sysNext, userKeep};
        idxQ        <= '0;
        userCountQ  <= userCntNext;
        errQ        <= (wgSizeX == '0) || (wgSizeY == '0) || (wgSizeZ == '0);
      end
      if (strb.saveCnt) begin
        countQ[strb.divSel] <= (wgSizeQ[strb.divSel] == '0) ? '0
                               : divQuo + RegW'(divRem != '0);
      end
      outValidQ <= strb.emit;
      if (strb.emit) begin
        outIdxQ     <= idxQ;
        outDataQ    <= slotData;
        idxQ        <= idxQ + 1'b1;
        pendQ[pick] <= 1'b0;
      end
    end
  end

  assign pendEmpty = (pendQ == '0);
  assign outValid  = outValidQ;
  assign outIdx    = outIdxQ;
  assign outData   = outDataQ;
  assign userCount = userCountQ;
  assign wgSizeErr = errQ;

endmodule

// File: rtl/wil_control.sv
module wil_control import wil_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      divDone,
  input  logic      pendEmpty,
  output dpStrobe_t strb,
  output logic      done
);
  localparam logic [1:0] LastDim = 2'(Dims - 1);

  ctlState_e  stateQ, stateD;
  logic [1:0] selQ, selD;
  logic       doneQ, doneD;

  always_comb begin
    stateD      = stateQ;
    selD        = selQ;
    doneD       = 1'b0;
    strb        = '0;
    strb.divSel = selQ;
    case (stateQ)
      CtlIdle: begin
        if (start) begin
          strb.latch = 1'b1;
          selD       = '0;
          stateD     = CtlDivLoad;
        end
      end
      CtlDivLoad: begin
        strb.divStart = 1'b1;
        stateD        = CtlDivWait;
      end
      CtlDivWait: begin
        if (divDone) begin
          strb.saveCnt = 1'b1;
          if (selQ == LastDim) begin
            stateD = CtlEmit;
          end else begin
            selD   = selQ + 1'b1;
            stateD = CtlDivLoad;
          end
        end
      end
      CtlEmit: begin
        if (!pendEmpty) begin
          strb.emit = 1'b1;
        end else begin
          doneD  = 1'b1;
          stateD = CtlIdle;
        end
      end
      default: stateD = CtlIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= CtlIdle;
      selQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      selQ   <= selD;
      doneQ  <= doneD;
    end
  end

  assign done = doneQ;

endmodule

// File: rtl/wave_init_loader.sv
module wave_init_loader import wil_pkg::*; #(
  parameter  int MaxUserRegs = 16,
  localparam int IdxW        = $clog2(MaxUserRegs + SysSlots),
  localparam int CntW        = $clog2(MaxUserRegs + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [UserFields-1:0] propEn,
  input  logic [SysSlots-1:0]   sysEn,
  input  logic [127:0]          segBufDesc,
  input  logic [63:0]           dispatchPtr,
  input  logic [63:0]           queuePtr,
  input  logic [63:0]           kernargPtr,
  input  logic [63:0]           dispatchId,
  input  logic [RegW-1:0]       scratchOffset,
  input  logic [RegW-1:0]       privSegBytes,
  input  logic [RegW-1:0]       gridX,
  input  logic [RegW-1:0]       gridY,
  input  logic [RegW-1:0]       gridZ,
  input  logic [RegW-1:0]       wgSizeX,
  input  logic [RegW-1:0]       wgSizeY,
  input  logic [RegW-1:0]       wgSizeZ,
  input  logic [RegW-1:0]       wgIdX,
  input  logic [RegW-1:0]       wgIdY,
  input  logic [RegW-1:0]       wgIdZ,
  input  logic                  firstWave,
  input  logic [10:0]           orderedTerm,
  input  logic [5:0]            wavesInGroup,
  input  logic [RegW-1:0]       waveByteOffset,
  output logic                  outValid,
  output logic [IdxW-1:0]       outIdx,
  output logic [RegW-1:0]       outData,
  output logic                  done,
  output logic [CntW-1:0]       userCount,
  output logic                  wgSizeErr
);

  dpStrobe_t strb;
  logic      divDone, pendEmpty;

  wil_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .divDone  (divDone),
    .pendEmpty(pendEmpty),
    .strb     (strb),
    .done     (done)
  );

  wil_datapath #(
    .MaxUserRegs(MaxUserRegs),
    .IdxW       (IdxW),
    .CntW       (CntW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .propEn        (propEn),
    .sysEn         (sysEn),
    .segBufDesc    (segBufDesc),
    .dispatchPtr   (dispatchPtr),
    .queuePtr      (queuePtr),
    .kernargPtr    (kernargPtr),
    .dispatchId    (dispatchId),
    .scratchOffset (scratchOffset),
    .privSegBytes  (privSegBytes),
    .gridX         (gridX),
    .gridY         (gridY),
    .gridZ         (gridZ),
    .wgSizeX       (wgSizeX),
    .wgSizeY       (wgSizeY),
    .wgSizeZ       (wgSizeZ),
    .wgIdX         (wgIdX),
    .wgIdY         (wgIdY),
    .wgIdZ         (wgIdZ),
    .firstWave     (firstWave),
    .orderedTerm   (orderedTerm),
    .wavesInGroup  (wavesInGroup),
    .waveByteOffset(waveByteOffset),
    .divDone       (divDone),
    .pendEmpty     (pendEmpty),
    .outValid      (outValid),
    .outIdx        (outIdx),
    .outData       (outData),
    .userCount     (userCount),
    .wgSizeErr     (wgSizeErr)
  );

endmodule

// File: rtl/wil_checker.sv
module wil_checker #(
  parameter  int MaxUserRegs = 16,
  localparam int IdxW        = $clog2(MaxUserRegs + 5),
  localparam int CntW        = $clog2(MaxUserRegs + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            outValid,
  input logic [IdxW-1:0] outIdx,
  input logic            done,
  input logic [CntW-1:0] userCount
);

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: no write in the done cycle
  a_r8_no_write_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

  // R8: a run of writes ends only into done
  a_r8_end_into_done: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && $past(outValid)) |-> done);

  // R2: consecutive writes have consecutive indices
  a_r2_dense_index: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outIdx == $past(outIdx) + 1'b1));

  // R2: index stays inside user plus system range
  a_r2_index_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outIdx) < MaxUserRegs + 5));

  // R3: reported count saturates
  a_r3_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    int'(userCount) <= MaxUserRegs);

endmodule

bind wave_init_loader wil_checker #(.MaxUserRegs(MaxUserRegs)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .outIdx   (outIdx),
  .done     (done),
  .userCount(userCount)
);

// File: tb/sim_wave_init_loader.sv
`timescale 1ns/1ps
module sim_wave_init_loader;

  typedef struct packed {
    logic [9:0]  uEn;
    logic [4:0]  sEn;
    logic [31:0] gX, wX, gY, wY, gZ, wZ, priv;
  } tcase_t;

  // stimulus table; expected sequences are computed by the model below
  localparam int NCases = 7;
  localparam tcase_t CASES [NCases] = '{
    '{10'h3FF, 5'h1F, 32'd1000, 32'd64, 32'd5, 32'd5, 32'd7, 32'd2, 32'h101},              // overflow cap
    '{10'h0C2, 5'h04, 32'd9, 32'd3, 32'd4, 32'd4, 32'd4, 32'd4, 32'h0},                    // sparse, Z forces Y
    '{10'h000, 5'h00, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'h0},                    // nothing enabled
    '{10'h380, 5'h18, 32'd100, 32'd7, 32'd64, 32'd8, 32'hFFFFFFFF, 32'd1, 32'h8},          // counts
    '{10'h1E0, 5'h00, 32'd1, 32'hFFFFFFFF, 32'd50, 32'd0, 32'd3, 32'd3, 32'h13},           // zero size
    '{10'h001, 5'h11, 32'd2, 32'd2, 32'd2, 32'd2, 32'd2, 32'd2, 32'h4},                    // buffer + sys
    '{10'h0FF, 5'h02, 32'd8, 32'd2, 32'd2, 32'd2, 32'd2, 32'd2, 32'hFFFFFFFE}              // exactly 16
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  propEn = '0;
  logic [4:0]  sysEn = '0;
  logic [127:0] segBufDesc = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
  logic [63:0] dispatchPtr = 64'hD1D1D1D1_D0D0D0D0;
  logic [63:0] queuePtr    = 64'hC1C1C1C1_C0C0C0C0;
  logic [63:0] kernargPtr  = 64'hE1E1E1E1_E0E0E0E0;
  logic [63:0] dispatchId  = 64'hF1F1F1F1_F0F0F0F0;
  logic [31:0] scratchOffset = 32'h5C5C0000;
  logic [31:0] privSegBytes = '0;
  logic [31:0] gridX = '0, gridY = '0, gridZ = '0;
  logic [31:0] wgSizeX = '0, wgSizeY = '0, wgSizeZ = '0;
  logic [31:0] wgIdX = 32'h100, wgIdY = 32'h200, wgIdZ = 32'h300;
  logic        firstWave = 1'b1;
  logic [10:0] orderedTerm = 11'h5A5;
  logic [5:0]  wavesInGroup = 6'h2A;
  logic [31:0] waveByteOffset = 32'h00007700;

  logic        outValid;
  logic [4:0]  outIdx;
  logic [31:0] outData;
  logic        done;
  logic [4:0]  userCount;
  logic        wgSizeErr;

  always #4 clk = ~clk;

  wave_init_loader u0 (
    .clk(clk), .rstN(rstN), .start(start), .propEn(propEn), .sysEn(sysEn),
    .segBufDesc(segBufDesc), .dispatchPtr(dispatchPtr), .queuePtr(queuePtr),
    .kernargPtr(kernargPtr), .dispatchId(dispatchId), .scratchOffset(scratchOffset),
    .privSegBytes(privSegBytes), .gridX(gridX), .gridY(gridY), .gridZ(gridZ),
    .wgSizeX(wgSizeX), .wgSizeY(wgSizeY), .wgSizeZ(wgSizeZ),
    .wgIdX(wgIdX), .wgIdY(wgIdY), .wgIdZ(wgIdZ), .firstWave(firstWave),
    .orderedTerm(orderedTerm), .wavesInGroup(wavesInGroup),
    .waveByteOffset(waveByteOffset), .outValid(outValid), .outIdx(outIdx),
    .outData(outData), .done(done), .userCount(userCount), .wgSizeErr(wgSizeErr)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // expected-sequence model
  logic [4:0]  expIdx [32];
  logic [31:0] expData [32];
  int          expN;
  int          uIdx;
  int          sIdx;
  logic [4:0]  expUc;
  logic        expErr;

  function automatic logic [31:0] ceilDiv(input logic [31:0] g, input logic [31:0] w);
    if (w == 32'd0) return 32'd0;
    return (g / w) + (((g % w) != 32'd0) ? 32'd1 : 32'd0);
  endfunction

  task automatic addUser(input logic [31:0] v);
    if (uIdx < 16) begin
      expIdx[expN] = 5'(uIdx);
      expData[expN] = v;
      expN++;
    end
    uIdx++;
  endtask

  task automatic addSys(input logic [31:0] v);
    expIdx[expN] = 5'(sIdx);
    expData[expN] = v;
    expN++;
    sIdx++;
  endtask

  task automatic buildExpected();
    logic [31:0] pr;
    pr = (privSegBytes + 32'd3) & 32'hFFFFFFFC;
    expN = 0;
    uIdx = 0;
    if (propEn[0]) begin
      for (int w = 0; w < 4; w++) addUser(segBufDesc[32*w +: 32]);
    end
    if (propEn[1]) begin addUser(dispatchPtr[31:0]); addUser(dispatchPtr[63:32]); end
    if (propEn[2]) begin addUser(queuePtr[31:0]);    addUser(queuePtr[63:32]);    end
    if (propEn[3]) begin addUser(kernargPtr[31:0]);  addUser(kernargPtr[63:32]);  end
    if (propEn[4]) begin addUser(dispatchId[31:0]);  addUser(dispatchId[63:32]);  end
    if (propEn[5]) begin addUser(scratchOffset);     addUser(pr);                 end
    if (propEn[6]) addUser(pr);
    if (propEn[7]) addUser(ceilDiv(gridX, wgSizeX));
    if (propEn[8]) addUser(ceilDiv(gridY, wgSizeY));
    if (propEn[9]) addUser(ceilDiv(gridZ, wgSizeZ));
    expUc = (uIdx > 16) ? 5'd16 : 5'(uIdx);
    sIdx = (uIdx > 16) ? 16 : uIdx;
    if (sysEn[0]) addSys(wgIdX);
    if (sysEn[1] || sysEn[2]) addSys(wgIdY);
    if (sysEn[2]) addSys(wgIdZ);
    if (sysEn[3]) addSys({firstWave, 14'b0, orderedTerm, wavesInGroup});
    if (sysEn[4]) addSys(waveByteOffset);
    expErr = (wgSizeX == 0) || (wgSizeY == 0) || (wgSizeZ == 0);
  endtask

  function automatic string caseTags(input int c);
    case (c)
      0: return "R1 R2 R3 R4 R5 R6";
      1: return "R1 R2 R7";
      2: return "R2 R8";
      3: return "R4 R6";
      4: return "R4 R5";
      5: return "R1 R6";
      6: return "R3 R6";
      default: return "R8";
    endcase
  endfunction

  task automatic runCase(input int c, input bit interfere);
    tcase_t t;
    logic [4:0]  gotIdx [32];
    logic [31:0] gotData [32];
    int gotN, lastCyc, doneCyc;
    bit seenDone, gap, inter, quiet;
    string tg;
    t = CASES[c];
    tg = caseTags(c);
    @(negedge clk);
    propEn = t.uEn; sysEn = t.sEn;
    gridX = t.gX; wgSizeX = t.wX;
    gridY = t.gY; wgSizeY = t.wY;
    gridZ = t.gZ; wgSizeZ = t.wZ;
    privSegBytes = t.priv;
    buildExpected();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotN = 0; lastCyc = -1; doneCyc = -1;
    seenDone = 1'b0; gap = 1'b0; inter = 1'b0;
    for (int cyc = 0; cyc < 1000 && !seenDone; cyc++) begin
      @(negedge clk);
      if (outValid) begin
        if (gotN < 32) begin
          gotIdx[gotN] = outIdx;
          gotData[gotN] = outData;
        end
        gotN++;
        lastCyc = cyc;
      end else if (gotN > 0 && !done) begin
        gap = 1'b1;
      end
      if (done) begin
        seenDone = 1'b1;
        doneCyc = cyc;
      end
      if (interfere && gotN == 3 && !inter) begin
        start = 1'b1; propEn = '0; sysEn = '0;
        wgSizeX = '0; wgSizeY = '0; wgSizeZ = '0; gridX = 32'h5;
        inter = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    chk(seenDone, {"R8 done seen, ", tg}, 64'(seenDone), 64'd1);
    chk(gotN == expN, {"R2 write count, ", tg}, 64'(gotN), 64'(expN));
    for (int k = 0; k < expN && k < gotN && k < 32; k++) begin
      chk({gotIdx[k], gotData[k]} == {expIdx[k], expData[k]},
          $sformatf("%s write %0d (idx,data)", tg, k),
          64'({gotIdx[k], gotData[k]}), 64'({expIdx[k], expData[k]}));
    end
    chk(userCount == expUc, {"R3 user count, ", tg}, 64'(userCount), 64'(expUc));
    chk(wgSizeErr == expErr, {"R4 size error flag, ", tg}, 64'(wgSizeErr), 64'(expErr));
    chk(!gap, {"R8 writes contiguous, ", tg}, 64'(gap), 64'd0);
    if (expN > 0) begin
      chk(doneCyc == lastCyc + 1, {"R8 done one cycle after last write, ", tg},
          64'(doneCyc), 64'(lastCyc + 1));
    end
    if (interfere) begin
      quiet = 1'b1;
      for (int q = 0; q < 6; q++) begin
        @(negedge clk);
        if (outValid || done) quiet = 1'b0;
      end
      chk(quiet, "R8 start during sequence ignored", 64'(quiet), 64'd1);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk(outValid == 1'b0, "R9 reset outValid", 64'(outValid), 64'd0);
    chk(outIdx == 5'd0, "R9 reset outIdx", 64'(outIdx), 64'd0);
    chk(outData == 32'd0, "R9 reset outData", 64'(outData), 64'd0);
    chk(done == 1'b0, "R9 reset done", 64'(done), 64'd0);
    chk(userCount == 5'd0, "R9 reset userCount", 64'(userCount), 64'd0);
    chk(wgSizeErr == 1'b0, "R9 reset wgSizeErr", 64'(wgSizeErr), 64'd0);
    for (int c = 0; c < NCases; c++) runCase(c, 1'b0);
    // R8: second start mid-sequence, with changed inputs
    runCase(0, 1'b1);
    // error flag clears on the next accepted start (R4)
    runCase(5, 1'b0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule